// File: doc/BRIEF.md
# Protected Register Unlock Controller

This block keeps a small group of safety-critical control fields closed to ordinary bus writes. Software opens them by writing a fixed three-byte key, one byte per write, to a dedicated lock register. Once the key is accepted, the block raises a lock-open status. It also raises a write qualifier that every protected register on the chip honours. While the block is closed, protected writes are dropped without any error.

Two protected items live inside the block as working examples. The first is a 16-bit field that switches off the power-on-reset monitor, but only while it holds one magic value. Any reset event from another source puts this field back to zero. The second is a pair of one-shot request bits, one for a whole-chip reset and one for a processor-core reset. Each bit produces a pulse of fixed length and then clears itself. Writes use a plain bus of address, data and write strobe, and take effect on the rising clock edge where the strobe is high.

Top module: `prot_unlock_ctrl`

## Requirements
- R1: After reset, lock_open and prot_wr_ok are 0, the key tracker is at its first step, por_field is 0x0000, por_off is 0, and both pulse outputs are 0.
- R2: Three writes to the lock register (address 0x100) whose data low bytes are 0x59, then 0x16, then 0x88 set lock_open and prot_wr_ok to 1. They rise in the cycle after the edge that accepts the 0x88 write, and not before.
- R3: While lock_open is 0, writes to the power-on-reset field (address 0x024) and to the one-shot register (address 0x008) have no effect. por_field keeps its value and no pulse appears.
- R4: A lock-register write that does not match the expected key byte sends the tracker back to its first step. A mismatching write of 0x59 counts as a new first step. Writes to other addresses leave the tracker where it is.
- R5: While lock_open is 1, a lock-register write whose low byte is anything other than 0x59 clears lock_open to 0. A write of 0x59 leaves lock_open at 1.
- R6: An accepted write to address 0x024 loads data bits 15:0 into por_field. por_off is 1 exactly when por_field equals 0x5AA5.
- R7: A high ext_rst_evt clears por_field to 0 at the next edge, whatever the lock state. It takes priority over a write in the same cycle.
- R8: An accepted write to address 0x008 with data bit 0 set raises chip_rst_pulse, and with data bit 1 set raises core_rst_pulse. Each pulse is high for exactly 2 cycles, starting in the cycle after the write. A 0 in a bit position has no effect.
- R9: Only data bits 7:0 of a lock-register write take part in key matching and relocking. Bits 31:8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address of the write |
| bus_wdata | input | 32 | Write data |
| ext_rst_evt | input | 1 | Reset event from another source; clears the POR disable field |
| lock_open | output | 1 | Lock status: 1 when protected writes are allowed |
| prot_wr_ok | output | 1 | Write qualifier for protected registers elsewhere |
| por_field | output | 16 | Current value of the POR disable field |
| por_off | output | 1 | 1 while the POR monitor is disabled by the magic value |
| chip_rst_pulse | output | 1 | Whole-chip reset request pulse |
| core_rst_pulse | output | 1 | Core reset request pulse |

## Verification
The bench goes after broken and restarted key sequences. It writes 0x59 twice in a row and sends a wrong middle byte. A tracker that fails to re-arm on 0x59 would stay locked after a valid restart, and one that only advances would open on a bad key. It also interleaves writes to other addresses between key bytes, relocks with both 0x59 and other bytes, and sets key bytes in the upper data bits. A design that reads those bits would open or close at the wrong time. Pulse length is counted cycle by cycle, so a one-shot that is one cycle short or long shows up. The bench also raises ext_rst_evt together with a POR field write, so a design that gives the write priority would keep the POR monitor off.

// File: rtl/prot_unlock_pkg.sv
package prot_unlock_pkg;

   // Progress of the three-byte key tracker
   typedef enum logic [1:0] {
      SEQ_WAIT0 = 2'd0,
      SEQ_WAIT1 = 2'd1,
      SEQ_WAIT2 = 2'd2
   } seq_step_e;

   localparam int unsigned KEY_BYTE_W = 8;

endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
   import prot_unlock_pkg::*;
#(
   parameter logic [KEY_BYTE_W-1:0] KEY0 = 8'h59,
   parameter logic [KEY_BYTE_W-1:0] KEY1 = 8'h16,
   parameter logic [KEY_BYTE_W-1:0] KEY2 = 8'h88
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hit_i,
   input  logic [KEY_BYTE_W-1:0] byte_i,
   output logic                  open_o
);

   seq_step_e step_q, step_d;
   logic      open_q, open_d;
   logic      done;

   generate
      if (KEY0 == KEY1 || KEY1 == KEY2 || KEY0 == KEY2) begin : g_bad_key
         $error("unlock_seq: key bytes must all differ");
      end
   endgenerate

   always_comb begin
      step_d = step_q;
      open_d = open_q;
      done   = 1'b0;
      if (hit_i) begin
         unique case (step_q)
            SEQ_WAIT1: step_d = (byte_i == KEY1) ? SEQ_WAIT2 :
                                (byte_i == KEY0) ? SEQ_WAIT1 : SEQ_WAIT0;
            SEQ_WAIT2: begin
               done   = (byte_i == KEY2);
               step_d = (byte_i == KEY0) ? SEQ_WAIT1 : SEQ_WAIT0;
            end
            default:   step_d = (byte_i == KEY0) ? SEQ_WAIT1 : SEQ_WAIT0;
         endcase
         if (done)
            open_d = 1'b1;
         else if (open_q && byte_i != KEY0)
            open_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= SEQ_WAIT0;
         open_q <= 1'b0;
      end else begin
         step_q <= step_d;
         open_q <= open_d;
      end
   end

   assign open_o = open_q;

   AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(hit_i) && $past(byte_i) == KEY2); // R2
   AST_OPEN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_i |=> $stable(open_q)); // R4
   AST_RELOCK_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && hit_i && byte_i == KEY0) |=> open_q); // R5

endmodule

// File: rtl/por_guard.sv
module por_guard #(
   parameter int unsigned          FIELD_W = 16,
   parameter logic [FIELD_W-1:0]   MAGIC   = 16'h5AA5
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_i,
   input  logic               open_i,
   input  logic               clr_i,
   input  logic [FIELD_W-1:0] data_i,
   output logic [FIELD_W-1:0] val_o,
   output logic               off_o
);

   logic [FIELD_W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         val_q <= '0;
      else if (clr_i)
         val_q <= '0;
      else if (hit_i && open_i)
         val_q <= data_i;
   end

   assign val_o = val_q;
   assign off_o = (val_q == MAGIC);

   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_i && !clr_i) |=> $stable(val_q)); // R3
   AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (val_q == '0) && !off_o); // R7

endmodule

// File: rtl/oneshot_bit.sv
module oneshot_bit #(
   parameter int unsigned PULSE_CYCLES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic pulse_o
);

   localparam int unsigned CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
   localparam int unsigned RUN_W = $clog2(PULSE_CYCLES + 2) + 1;

   logic q;

   generate
      if (PULSE_CYCLES < 1) begin : g_bad_len
         $error("oneshot_bit: PULSE_CYCLES must be at least 1");
      end
      if (PULSE_CYCLES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_i;
         end
      end else begin : g_counted
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q     <= 1'b0;
               cnt_q <= '0;
            end else if (set_i) begin
               q     <= 1'b1;
               cnt_q <= CNT_W'(PULSE_CYCLES - 1);
            end else if (q) begin
               if (cnt_q == '0) q <= 1'b0;
               else             cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   endgenerate

   assign pulse_o = q;

   // Independent run-length count for the width check
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (set_i)
         run_q <= RUN_W'(1);
      else if (q && run_q != '1)
         run_q <= run_q + 1'b1;
      else if (!q)
         run_q <= '0;
   end

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q); // R8
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      q |-> run_q <= RUN_W'(PULSE_CYCLES)); // R8

endmodule

// File: rtl/prot_unlock_ctrl.sv
module prot_unlock_ctrl
   import prot_unlock_pkg::*;
#(
   parameter int unsigned        ADDR_W       = 12,
   parameter int unsigned        DATA_W       = 32,
   parameter int unsigned        POR_W        = 16,
   parameter logic [ADDR_W-1:0]  LOCK_ADDR    = 12'h100,
   parameter logic [ADDR_W-1:0]  POR_ADDR     = 12'h024,
   parameter logic [ADDR_W-1:0]  SHOT_ADDR    = 12'h008,
   parameter logic [POR_W-1:0]   POR_MAGIC    = 16'h5AA5,
   parameter int unsigned        PULSE_CYCLES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              ext_rst_evt,
   output logic              lock_open,
   output logic              prot_wr_ok,
   output logic [POR_W-1:0]  por_field,
   output logic              por_off,
   output logic              chip_rst_pulse,
   output logic              core_rst_pulse
);

   localparam int unsigned NUM_SHOT = 2;

   generate
      if (DATA_W < POR_W || DATA_W < KEY_BYTE_W || DATA_W < NUM_SHOT) begin : g_bad_data
         $error("prot_unlock_ctrl: DATA_W too narrow for the fields");
      end
      if (LOCK_ADDR == POR_ADDR || LOCK_ADDR == SHOT_ADDR || POR_ADDR == SHOT_ADDR) begin : g_bad_map
         $error("prot_unlock_ctrl: register addresses must differ");
      end
   endgenerate

   logic lock_hit, por_hit, shot_hit;
   logic open_w;
   logic [NUM_SHOT-1:0] shot_pulse;

   assign lock_hit = bus_wr && (bus_addr == LOCK_ADDR);
   assign por_hit  = bus_wr && (bus_addr == POR_ADDR);
   assign shot_hit = bus_wr && (bus_addr == SHOT_ADDR);

   unlock_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (lock_hit),
      .byte_i (bus_wdata[KEY_BYTE_W-1:0]),
      .open_o (open_w)
   );

   por_guard #(
      .FIELD_W (POR_W),
      .MAGIC   (POR_MAGIC)
   ) u_por (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (por_hit),
      .open_i (open_w),
      .clr_i  (ext_rst_evt),
      .data_i (bus_wdata[POR_W-1:0]),
      .val_o  (por_field),
      .off_o  (por_off)
   );

   for (genvar i = 0; i < NUM_SHOT; i++) begin : g_shot
      oneshot_bit #(
         .PULSE_CYCLES (PULSE_CYCLES)
      ) u_bit (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (shot_hit && open_w && bus_wdata[i]),
         .pulse_o (shot_pulse[i])
      );
   end

   assign lock_open      = open_w;
   assign prot_wr_ok     = open_w;
   assign chip_rst_pulse = shot_pulse[0];
   assign core_rst_pulse = shot_pulse[1];

   AST_LOCKED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (shot_hit && !lock_open && !chip_rst_pulse) |=> !chip_rst_pulse); // R3

endmodule

// File: tb/prot_unlock_ctrl_tb.sv
module prot_unlock_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        ext_rst_evt = 1'b0;
   logic        lock_open, prot_wr_ok, por_off, chip_rst_pulse, core_rst_pulse;
   logic [15:0] por_field;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   prot_unlock_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ext_rst_evt(ext_rst_evt),
      .lock_open(lock_open), .prot_wr_ok(prot_wr_ok), .por_field(por_field),
      .por_off(por_off), .chip_rst_pulse(chip_rst_pulse),
      .core_rst_pulse(core_rst_pulse)
   );

   // Behavioural reference model
   int m_step = 0;
   bit m_open = 0;
   int m_por  = 0;
   int m_chip = 0;
   int m_core = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_step = 0; m_open = 0; m_por = 0; m_chip = 0; m_core = 0;
      end else begin
         int b;
         bit was_open;
         b = int'(bus_wdata[7:0]);
         was_open = m_open;
         if (m_chip > 0) m_chip--;
         if (m_core > 0) m_core--;
         if (bus_wr && bus_addr == 12'h100) begin
            if (m_step == 2 && b == 'h88) m_open = 1;
            else if (m_open && b != 'h59) m_open = 0;
            if (m_step == 0) m_step = (b == 'h59) ? 1 : 0;
            else if (m_step == 1) m_step = (b == 'h16) ? 2 : (b == 'h59) ? 1 : 0;
            else m_step = (b == 'h59) ? 1 : 0;
         end
         if (ext_rst_evt) m_por = 0;
         else if (bus_wr && bus_addr == 12'h024 && was_open) m_por = int'(bus_wdata[15:0]);
         if (bus_wr && bus_addr == 12'h008 && was_open) begin
            if (bus_wdata[0]) m_chip = 2;
            if (bus_wdata[1]) m_core = 2;
         end
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(cur_req, "lock_open", 32'(lock_open), 32'(m_open));
      chk(cur_req, "prot_wr_ok", 32'(prot_wr_ok), 32'(m_open));
      chk(cur_req, "por_field", 32'(por_field), 32'(m_por));
      chk(cur_req, "por_off", 32'(por_off), 32'(m_por == 'h5AA5));
      chk(cur_req, "chip_rst_pulse", 32'(chip_rst_pulse), 32'(m_chip > 0));
      chk(cur_req, "core_rst_pulse", 32'(core_rst_pulse), 32'(m_core > 0));
   endtask

   task automatic tick();
      @(negedge clk);
      if (rst_n) compare_all();
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic unlock();
      wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h88);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      cur_req = "R1";
      chk("R1", "lock_open", 32'(lock_open), 0);
      chk("R1", "por_field", 32'(por_field), 0);
      chk("R1", "pulses", 32'({chip_rst_pulse, core_rst_pulse}), 0);

      // R3 locked writes discarded
      cur_req = "R3";
      wr(12'h024, 32'h5AA5);
      wr(12'h008, 32'h3);
      tick();
      chk("R3", "por_field locked", 32'(por_field), 0);
      chk("R3", "no pulse locked", 32'({chip_rst_pulse, core_rst_pulse}), 0);

      // R4 broken sequences
      cur_req = "R4";
      wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h00); wr(12'h100, 32'h88);
      chk("R4", "wrong middle stays locked", 32'(lock_open), 0);
      wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h16); wr(12'h100, 32'h88);
      chk("R4", "repeated 0x16 stays locked", 32'(lock_open), 0);
      wr(12'h100, 32'h59); wr(12'h100, 32'h59); wr(12'h100, 32'h16);
      wr(12'h024, 32'h1234);
      wr(12'h100, 32'h88);
      chk("R4", "restart on 0x59 with foreign write opens", 32'(lock_open), 1);
      chk("R4", "foreign write while locked dropped", 32'(por_field), 0);

      // R5 relock rules
      cur_req = "R5";
      wr(12'h100, 32'h59);
      chk("R5", "0x59 keeps open", 32'(lock_open), 1);
      wr(12'h100, 32'h01);
      chk("R5", "other byte relocks", 32'(lock_open), 0);

      // R2 opens only after the third byte
      cur_req = "R2";
      wr(12'h100, 32'h59); wr(12'h100, 32'h16);
      chk("R2", "open before last byte", 32'(lock_open), 0);
      wr(12'h100, 32'h88);
      chk("R2", "open after key", 32'(prot_wr_ok), 1);
      wr(12'h100, 32'h00);

      // R9 upper bits ignored
      cur_req = "R9";
      wr(12'h100, 32'hABCD_0059); wr(12'h100, 32'hFFFF_FF16); wr(12'h100, 32'h1234_5688);
      chk("R9", "upper bits ignored on unlock", 32'(lock_open), 1);
      wr(12'h100, 32'h0000_5900);
      chk("R9", "upper 0x59 does not keep open", 32'(lock_open), 0);

      // R6 magic value
      cur_req = "R6";
      unlock();
      wr(12'h024, 32'hFFFF_5AA5);
      chk("R6", "magic disables POR", 32'(por_off), 1);
      wr(12'h024, 32'h5AA4);
      chk("R6", "other value enables POR", 32'(por_off), 0);
      chk("R6", "field value", 32'(por_field), 32'h5AA4);
      wr(12'h024, 32'h5AA5);

      // R7 external reset clears, beats a write
      cur_req = "R7";
      ext_rst_evt = 1'b1; tick(); ext_rst_evt = 1'b0;
      chk("R7", "ext reset clears", 32'(por_field), 0);
      wr(12'h024, 32'h5AA5);
      ext_rst_evt = 1'b1; bus_wr = 1'b1; bus_addr = 12'h024; bus_wdata = 32'h5AA5;
      tick();
      ext_rst_evt = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      chk("R7", "clear wins over write", 32'(por_off), 0);

      // R8 one-shot pulses
      cur_req = "R8";
      wr(12'h008, 32'h1);
      chk("R8", "chip pulse cycle 1", 32'(chip_rst_pulse), 1);
      tick();
      chk("R8", "chip pulse cycle 2", 32'(chip_rst_pulse), 1);
      tick();
      chk("R8", "chip pulse ended", 32'(chip_rst_pulse), 0);
      wr(12'h008, 32'h2);
      chk("R8", "core pulse only", 32'({chip_rst_pulse, core_rst_pulse}), 32'b01);
      repeat (3) tick();
      wr(12'h008, 32'h3);
      chk("R8", "both pulses", 32'({chip_rst_pulse, core_rst_pulse}), 32'b11);
      repeat (3) tick();
      wr(12'h008, 32'h0);
      chk("R8", "zero write no pulse", 32'({chip_rst_pulse, core_rst_pulse}), 0);
      wr(12'h100, 32'h00);
      cur_req = "R3";
      wr(12'h008, 32'h3);
      chk("R3", "locked one-shot dropped", 32'({chip_rst_pulse, core_rst_pulse}), 0);
      repeat (3) tick();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule